// File: doc/BRIEF.md
# Linked-List Descriptor DMA Channel

This block is one DMA channel that works through a chain of descriptors held in memory. Software gives the channel a starting destination address and the address of the first descriptor, then pulses a start input. Once the global enable is also high, the engine fetches that descriptor over a word-wide memory port. It takes the source address, the next pointer and a control word from the descriptor, and copies one block of words from source to destination. The destination address is never taken from a descriptor. It keeps running from the programmed start value across every block of the chain.

Each word moves as a read of the source followed by a write of the same data to the destination. Words are grouped into transactions. Each side of the channel paces transactions through its own handshake. In hardware mode this is a request level answered by a one-cycle acknowledge. In software mode it is a latched request pulse. The engine keeps five interrupt flags. Each has a raw bit, a masked status bit and a write-one-to-clear input. The channel does not wait for software to clear the block flag before it fetches the next descriptor.

The memory port follows valid/ready rules, with `mem_req` as valid and `mem_gnt` as ready. Once `mem_req` is raised, `mem_addr`, `mem_we` and `mem_wdata` hold steady until a cycle with `mem_gnt` high accepts the access. Only one access is ever outstanding. Its single response, `mem_rvalid` together with `mem_rdata` and `mem_err`, may come in any later cycle. The engine issues no new access until that response has arrived. A response is expected for writes as well as reads.

Top module: `ll_dma_chan`

## Requirements
- R1: No memory access is made until the channel enable and `glb_en` are both 1. The channel enable is set by a `ch_start` pulse while the channel is idle. The first descriptor is fetched from the `start_llp` value captured on that pulse.
- R2: A descriptor fetch reads four words at pointer+0, +4, +8 and +12. These hold, in order, the source address, a destination word, the next pointer and the control word. The destination word is discarded. The destination address starts at `start_dar` and continues across descriptors.
- R3: The control word is laid out as follows.
  - Bits [11:0] give the block length in words.
  - Bits [13:12] give the source address mode and bits [15:14] the destination address mode: 00 steps +4 per word, 01 steps -4, 10 or 11 holds the address fixed.
  - Bit 16 marks the last descriptor.
  - Bits [18:17] give the burst size n, meaning 2^n words per transaction.
- R4: Every word is read from the source address and the same data is then written to the destination address. A transaction moves min(burst size, words remaining) words.
- R5: At the end of a block, the chain ends if the last bit is set or the next pointer is zero. When it ends, the channel enable clears, the transfer-complete flag sets and no further descriptor is fetched.
- R6: When a block ends and the chain does not end, the block flag sets and the descriptor at the next pointer is fetched straight away. The engine does not wait for the flag to be cleared.
- R7: Each side has a handshake select, `src_sw_sel` or `dst_sw_sel`.
  - With select 0, a transaction waits for that side's `*_req` to be high. A one-cycle `*_ack` follows the last write of every transaction.
  - With select 1, a transaction waits for a latched `*_sw_req` pulse and no acknowledge is given.
  - The request input of the mode that is not selected is ignored.
- R8: `mem_req` and its address, write flag and data hold until granted. At most one access is outstanding. Memory is accessed only while the channel is enabled.
- R9: An error response sets the error flag, clears the channel enable and stops the chain without setting transfer-complete.
- R10: The interrupt bits are [0] transfer complete, [1] block complete, [2] source transaction, [3] destination transaction and [4] error.
  - A raw bit sets on its event and clears when the same bit of `irq_clr` is 1. A set in the same cycle wins over the clear.
  - `irq_stat` = raw AND `irq_mask`, and `irq` is the OR of `irq_stat`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glb_en | input | 1 | Global enable for transfers |
| ch_start | input | 1 | Pulse: capture start addresses and set channel enable |
| start_dar | input | AW | Starting destination address |
| start_llp | input | AW | Address of the first descriptor |
| src_sw_sel | input | 1 | Source handshake select, 0 hardware, 1 software |
| dst_sw_sel | input | 1 | Destination handshake select, 0 hardware, 1 software |
| ch_active | output | 1 | Channel enable state |
| src_req | input | 1 | Source hardware request |
| src_sw_req | input | 1 | Source software request pulse |
| src_ack | output | 1 | Source transaction acknowledge |
| dst_req | input | 1 | Destination hardware request |
| dst_sw_req | input | 1 | Destination software request pulse |
| dst_ack | output | 1 | Destination transaction acknowledge |
| mem_req | output | 1 | Memory access valid |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | DW | Memory write data |
| mem_gnt | input | 1 | Memory accepts the access (ready) |
| mem_rvalid | input | 1 | Memory response valid |
| mem_rdata | input | DW | Memory read data |
| mem_err | input | 1 | Response carries an error |
| irq_mask | input | 5 | Interrupt mask |
| irq_clr | input | 5 | Write-one-to-clear for raw flags |
| irq_raw | output | 5 | Raw interrupt flags |
| irq_stat | output | 5 | Masked interrupt flags |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the channel with its defaults: 32-bit addresses and data, and a 12-bit length field. Short blocks, bursts of one and four words, and every address mode can therefore be driven through the control word alone. Its memory model refuses the grant one cycle in four, so every memory access is held under back-pressure at some point of a run. It also answers a chosen address with an error, which reaches the error stop partway through a chain.

// File: rtl/ll_dma_pkg.sv
package ll_dma_pkg;

  // control word field positions
  localparam int CTL_SMODE_LSB = 12;
  localparam int CTL_DMODE_LSB = 14;
  localparam int CTL_LAST_BIT  = 16;
  localparam int CTL_BURST_LSB = 17;

  // interrupt bit positions
  localparam int IRQ_TFR = 0;
  localparam int IRQ_BLK = 1;
  localparam int IRQ_SRC = 2;
  localparam int IRQ_DST = 3;
  localparam int IRQ_ERR = 4;
  localparam int NIRQ    = 5;

  // descriptor word slots
  localparam logic [1:0] DW_SRC  = 2'd0;
  localparam logic [1:0] DW_DST  = 2'd1;
  localparam logic [1:0] DW_NEXT = 2'd2;
  localparam logic [1:0] DW_CTL  = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_WAIT, ST_RD, ST_WR, ST_ACK, ST_BEND
  } eng_state_e;

  function automatic logic [31:0] step_word(input logic [31:0] a, input logic [1:0] m);
    case (m)
      2'b00:   step_word = a + 32'd4;
      2'b01:   step_word = a - 32'd4;
      default: step_word = a;
    endcase
  endfunction

endpackage

// File: rtl/ll_dma_astep.sv
module ll_dma_astep #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step,
  input  logic [1:0]    mode,
  output logic [AW-1:0] addr
);
  localparam logic [AW-1:0] WSTEP = AW'(4);

  logic [AW-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (load) begin
      addr_q <= load_val;
    end else if (step) begin
      case (mode)
        2'b00:   addr_q <= addr_q + WSTEP;
        2'b01:   addr_q <= addr_q - WSTEP;
        default: addr_q <= addr_q;
      endcase
    end
  end

  assign addr = addr_q;
endmodule

// File: rtl/ll_dma_hs.sv
module ll_dma_hs (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_sel,
  input  logic hw_req,
  input  logic sw_req,
  input  logic take,
  input  logic done,
  output logic pend,
  output logic ack
);
  logic sw_pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_pend_q <= 1'b0;
    end else if (sw_sel && sw_req) begin
      sw_pend_q <= 1'b1;
    end else if (take) begin
      sw_pend_q <= 1'b0;
    end
  end

  assign pend = sw_sel ? sw_pend_q : hw_req;
  assign ack  = done && !sw_sel;
endmodule

// File: rtl/ll_dma_irq.sv
module ll_dma_irq #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] mask,
  output logic [N-1:0] raw,
  output logic [N-1:0] stat,
  output logic         any
);
  logic [N-1:0] raw_q;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       raw_q[i] <= 1'b0;
      else if (set[i])  raw_q[i] <= 1'b1;
      else if (clr[i])  raw_q[i] <= 1'b0;
    end
  end

  assign raw  = raw_q;
  assign stat = raw_q & mask;
  assign any  = |stat;
endmodule

// File: rtl/ll_dma_ctrl.sv
module ll_dma_ctrl
  import ll_dma_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int LENW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          glb_en,
  input  logic          ch_start,
  input  logic [AW-1:0] start_llp,
  input  logic [1:0]    side_pend,
  input  logic [AW-1:0] src_addr,
  input  logic [AW-1:0] dst_addr,
  output logic          src_load,
  output logic          src_step,
  output logic          dst_load,
  output logic          dst_step,
  output logic [1:0]    src_mode,
  output logic [1:0]    dst_mode,
  output logic          take,
  output logic          done,
  output logic          ev_tfr,
  output logic          ev_blk,
  output logic          ev_err,
  output logic          en,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_gnt,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_err
);
  eng_state_e      state_q;
  logic [1:0]      fidx_q;
  logic            pend_q;
  logic            en_q;
  logic [AW-1:0]   fptr_q;
  logic [AW-1:0]   llp_q;
  logic [LENW-1:0] left_q;
  logic [LENW-1:0] beats_q;
  logic [DW-1:0]   hold_q;
  logic [1:0]      smode_q, dmode_q, burst_q;
  logic            last_q;

  logic            rsp_ok, rsp_bad, chain_end;
  logic [LENW-1:0] burst_words, first_beats;

  assign rsp_ok      = pend_q && mem_rvalid && !mem_err;
  assign rsp_bad     = pend_q && mem_rvalid && mem_err;
  assign chain_end   = last_q || (llp_q == '0);
  assign burst_words = LENW'(1) << burst_q;
  assign first_beats = (left_q < burst_words) ? left_q : burst_words;

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = fptr_q + AW'({fidx_q, 2'b00});
    mem_wdata = hold_q;
    case (state_q)
      ST_FETCH: mem_req = !pend_q;
      ST_RD: begin
        mem_req  = !pend_q;
        mem_addr = src_addr;
      end
      ST_WR: begin
        mem_req  = !pend_q;
        mem_we   = 1'b1;
        mem_addr = dst_addr;
      end
      default: ;
    endcase
  end

  assign src_load = (state_q == ST_FETCH) && rsp_ok && (fidx_q == DW_SRC);
  assign src_step = (state_q == ST_RD) && rsp_ok;
  assign dst_step = (state_q == ST_WR) && rsp_ok;
  assign dst_load = ch_start && !en_q;
  assign take     = (state_q == ST_WAIT) && (left_q != '0) && (&side_pend);
  assign done     = (state_q == ST_ACK);
  assign ev_blk   = (state_q == ST_BEND);
  assign ev_tfr   = (state_q == ST_BEND) && chain_end;
  assign ev_err   = rsp_bad;
  assign src_mode = smode_q;
  assign dst_mode = dmode_q;
  assign en       = en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (mem_req && mem_gnt) begin
      pend_q <= 1'b1;
    end else if (mem_rvalid) begin
      pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      fidx_q  <= '0;
      en_q    <= 1'b0;
      fptr_q  <= '0;
      llp_q   <= '0;
      left_q  <= '0;
      beats_q <= '0;
      hold_q  <= '0;
      smode_q <= '0;
      dmode_q <= '0;
      burst_q <= '0;
      last_q  <= 1'b0;
    end else if (rsp_bad) begin
      en_q    <= 1'b0;
      state_q <= ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (ch_start && !en_q) begin
            en_q   <= 1'b1;
            fptr_q <= start_llp;
          end else if (en_q && glb_en) begin
            fidx_q  <= '0;
            state_q <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (rsp_ok) begin
            case (fidx_q)
              DW_NEXT: llp_q <= mem_rdata[AW-1:0];
              DW_CTL: begin
                left_q  <= mem_rdata[LENW-1:0];
                smode_q <= mem_rdata[CTL_SMODE_LSB +: 2];
                dmode_q <= mem_rdata[CTL_DMODE_LSB +: 2];
                last_q  <= mem_rdata[CTL_LAST_BIT];
                burst_q <= mem_rdata[CTL_BURST_LSB +: 2];
              end
              default: ;
            endcase
            fidx_q <= fidx_q + 2'd1;
            if (fidx_q == DW_CTL) state_q <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (left_q == '0) begin
            state_q <= ST_BEND;
          end else if (&side_pend) begin
            beats_q <= first_beats;
            state_q <= ST_RD;
          end
        end
        ST_RD: begin
          if (rsp_ok) begin
            hold_q  <= mem_rdata;
            state_q <= ST_WR;
          end
        end
        ST_WR: begin
          if (rsp_ok) begin
            left_q  <= left_q - LENW'(1);
            beats_q <= beats_q - LENW'(1);
            state_q <= (beats_q == LENW'(1)) ? ST_ACK : ST_RD;
          end
        end
        ST_ACK: state_q <= ST_WAIT;
        ST_BEND: begin
          if (chain_end) begin
            en_q    <= 1'b0;
            state_q <= ST_IDLE;
          end else begin
            fptr_q  <= llp_q;
            fidx_q  <= '0;
            state_q <= ST_FETCH;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ll_dma_chan.sv
module ll_dma_chan
  import ll_dma_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int LENW = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            glb_en,
  input  logic            ch_start,
  input  logic [AW-1:0]   start_dar,
  input  logic [AW-1:0]   start_llp,
  input  logic            src_sw_sel,
  input  logic            dst_sw_sel,
  output logic            ch_active,
  input  logic            src_req,
  input  logic            src_sw_req,
  output logic            src_ack,
  input  logic            dst_req,
  input  logic            dst_sw_req,
  output logic            dst_ack,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic            mem_gnt,
  input  logic            mem_rvalid,
  input  logic [DW-1:0]   mem_rdata,
  input  logic            mem_err,
  input  logic [NIRQ-1:0] irq_mask,
  input  logic [NIRQ-1:0] irq_clr,
  output logic [NIRQ-1:0] irq_raw,
  output logic [NIRQ-1:0] irq_stat,
  output logic            irq
);
  localparam int NSIDE = 2;

  logic [NSIDE-1:0]         hs_sel, hs_hw, hs_sw, hs_ack, side_pend;
  logic [NSIDE-1:0]         a_load, a_step;
  logic [NSIDE-1:0][1:0]    a_mode;
  logic [NSIDE-1:0][AW-1:0] a_lval, a_addr;
  logic                     take, done, ev_tfr, ev_blk, ev_err;
  logic [NIRQ-1:0]          ev_set;

  assign hs_sel = {dst_sw_sel, src_sw_sel};
  assign hs_hw  = {dst_req, src_req};
  assign hs_sw  = {dst_sw_req, src_sw_req};
  assign src_ack = hs_ack[0];
  assign dst_ack = hs_ack[1];
  assign a_lval[0] = mem_rdata[AW-1:0];
  assign a_lval[1] = start_dar;

  ll_dma_ctrl #(.AW(AW), .DW(DW), .LENW(LENW)) u_ctrl (
    .clk, .rst_n, .glb_en, .ch_start, .start_llp,
    .side_pend,
    .src_addr (a_addr[0]),
    .dst_addr (a_addr[1]),
    .src_load (a_load[0]),
    .src_step (a_step[0]),
    .dst_load (a_load[1]),
    .dst_step (a_step[1]),
    .src_mode (a_mode[0]),
    .dst_mode (a_mode[1]),
    .take, .done, .ev_tfr, .ev_blk, .ev_err,
    .en (ch_active),
    .mem_req, .mem_we, .mem_addr, .mem_wdata,
    .mem_gnt, .mem_rvalid, .mem_rdata, .mem_err
  );

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    ll_dma_hs u_hs (
      .clk, .rst_n,
      .sw_sel (hs_sel[s]),
      .hw_req (hs_hw[s]),
      .sw_req (hs_sw[s]),
      .take,
      .done,
      .pend   (side_pend[s]),
      .ack    (hs_ack[s])
    );
    ll_dma_astep #(.AW(AW)) u_astep (
      .clk, .rst_n,
      .load     (a_load[s]),
      .load_val (a_lval[s]),
      .step     (a_step[s]),
      .mode     (a_mode[s]),
      .addr     (a_addr[s])
    );
  end

  always_comb begin
    ev_set          = '0;
    ev_set[IRQ_TFR] = ev_tfr;
    ev_set[IRQ_BLK] = ev_blk;
    ev_set[IRQ_SRC] = done;
    ev_set[IRQ_DST] = done;
    ev_set[IRQ_ERR] = ev_err;
  end

  ll_dma_irq #(.N(NIRQ)) u_irq (
    .clk, .rst_n,
    .set  (ev_set),
    .clr  (irq_clr),
    .mask (irq_mask),
    .raw  (irq_raw),
    .stat (irq_stat),
    .any  (irq)
  );
endmodule

// File: rtl/ll_dma_chan_chk.sv
module ll_dma_chan_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_gnt,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          src_ack,
  input logic          dst_ack,
  input logic          src_sw_sel,
  input logic          dst_sw_sel,
  input logic          ch_active,
  input logic [4:0]    irq_raw
);
  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  assert_req_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ch_active);

  assert_src_ack_hw_R7: assert property (@(posedge clk) disable iff (!rst_n)
    src_ack |-> !src_sw_sel);

  assert_dst_ack_hw_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dst_ack |-> !dst_sw_sel);

  assert_src_ack_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    src_ack |=> !src_ack);

  assert_tfr_stops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_raw[0]) |-> !ch_active);

  assert_err_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_raw[4]) |-> !ch_active);
endmodule

bind ll_dma_chan ll_dma_chan_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mem_req    (mem_req),
  .mem_gnt    (mem_gnt),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .src_ack    (src_ack),
  .dst_ack    (dst_ack),
  .src_sw_sel (src_sw_sel),
  .dst_sw_sel (dst_sw_sel),
  .ch_active  (ch_active),
  .irq_raw    (irq_raw)
);

// File: tb/ll_dma_chan_tb_top.sv
`timescale 1ns/1ps
module ll_dma_chan_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        glb_en = 1'b0, ch_start = 1'b0;
  logic [31:0] start_dar = '0, start_llp = '0;
  logic        src_sw_sel = 1'b0, dst_sw_sel = 1'b0;
  logic        ch_active;
  logic        src_req, dst_req;
  logic        src_sw_req = 1'b0, dst_sw_req = 1'b0;
  logic        src_ack, dst_ack;
  logic        mem_req, mem_we, mem_gnt, mem_rvalid, mem_err;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [4:0]  irq_mask = '0, irq_clr = '0, irq_raw, irq_stat;
  logic        irq;

  logic        src_auto = 1'b0, dst_auto = 1'b0;
  logic        bd_we = 1'b0, bd_clr = 1'b0, cnt_clr = 1'b0;
  logic [31:0] bd_addr = '0, bd_data = '0;
  logic [31:0] err_addr = 32'hFFFF_FFF0, probe_addr = 32'hFFFF_FFF0;
  logic [31:0] mem [0:255];
  logic [1:0]  gcnt;
  int          n_wr, n_sack, n_dack, n_probe, n_req;
  int          n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  ll_dma_chan dut_i (
    .clk, .rst_n, .glb_en, .ch_start, .start_dar, .start_llp,
    .src_sw_sel, .dst_sw_sel, .ch_active,
    .src_req, .src_sw_req, .src_ack, .dst_req, .dst_sw_req, .dst_ack,
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_gnt, .mem_rvalid,
    .mem_rdata, .mem_err, .irq_mask, .irq_clr, .irq_raw, .irq_stat, .irq
  );

  assign mem_gnt = (gcnt != 2'd3);

  // memory model, peripherals and event counters
  always @(posedge clk) begin
    if (!rst_n) begin
      gcnt <= '0; mem_rvalid <= 1'b0; mem_err <= 1'b0; mem_rdata <= '0;
      src_req <= 1'b0; dst_req <= 1'b0;
      n_wr <= 0; n_sack <= 0; n_dack <= 0; n_probe <= 0; n_req <= 0;
    end else begin
      gcnt <= gcnt + 2'd1;
      src_req <= src_auto && !src_ack;
      dst_req <= dst_auto && !dst_ack;
      if (bd_clr) for (int i = 0; i < 256; i++) mem[i] <= 32'h5EB7_0000 | i;
      if (bd_we) mem[bd_addr[9:2]] <= bd_data;
      mem_rvalid <= mem_req && mem_gnt;
      if (mem_req && mem_gnt) begin
        mem_rdata <= mem[mem_addr[9:2]];
        mem_err   <= (mem_addr == err_addr);
        if (mem_we && mem_addr != err_addr) mem[mem_addr[9:2]] <= mem_wdata;
      end
      if (cnt_clr) begin
        n_wr <= 0; n_sack <= 0; n_dack <= 0; n_probe <= 0; n_req <= 0;
      end else begin
        if (mem_req) n_req <= n_req + 1;
        if (mem_req && mem_gnt && mem_we) n_wr <= n_wr + 1;
        if (mem_req && mem_gnt && !mem_we && mem_addr == probe_addr) n_probe <= n_probe + 1;
        if (src_ack) n_sack <= n_sack + 1;
        if (dst_ack) n_dack <= n_dack + 1;
      end
    end
  end

  function automatic logic [31:0] pat(input logic [31:0] a);
    return 32'hA500_0000 | a;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); bd_we = 1'b1; bd_addr = a; bd_data = d;
    @(negedge clk); bd_we = 1'b0;
  endtask

  task automatic fill(input logic [31:0] base, input int n);
    for (int k = 0; k < n; k++) poke(base + 32'(4*k), pat(base + 32'(4*k)));
  endtask

  task automatic put_desc(input logic [31:0] base, input logic [31:0] s,
                          input logic [31:0] d, input logic [31:0] nx, input logic [31:0] c);
    poke(base, s); poke(base + 4, d); poke(base + 8, nx); poke(base + 12, c);
  endtask

  task automatic fresh();
    @(negedge clk); bd_clr = 1'b1; cnt_clr = 1'b1; irq_clr = 5'h1F;
    @(negedge clk); bd_clr = 1'b0; cnt_clr = 1'b0; irq_clr = 5'h00;
  endtask

  task automatic start_chan(input logic [31:0] dar, input logic [31:0] llp);
    @(negedge clk); start_dar = dar; start_llp = llp; ch_start = 1'b1;
    @(negedge clk); ch_start = 1'b0;
  endtask

  task automatic wait_idle(input string tag, input int max);
    int i;
    i = 0;
    repeat (3) @(negedge clk);
    while (ch_active && i < max) begin
      @(negedge clk); i++;
    end
    chk({tag, " channel stops"}, {31'd0, ch_active}, 32'd0);
  endtask

  task automatic t_reset();
    chk("R10 raw after reset", {27'd0, irq_raw}, 32'd0);
    chk("R10 irq after reset", {31'd0, irq}, 32'd0);
    chk("R1 inactive after reset", {31'd0, ch_active}, 32'd0);
    chk("R8 no req after reset", {31'd0, mem_req}, 32'd0);
  endtask

  // R1: nothing happens until global enable; then a one-word chain runs
  task automatic t_gate();
    fresh();
    src_auto = 1'b1; dst_auto = 1'b1; glb_en = 1'b0;
    fill(32'h100, 1);
    put_desc(32'h040, 32'h100, 32'h3F0, 32'h0, 32'd1);
    start_chan(32'h200, 32'h040);
    repeat (20) @(negedge clk);
    chk("R1 no access while global enable low", n_req, 0);
    chk("R1 channel enabled", {31'd0, ch_active}, 32'd1);
    glb_en = 1'b1;
    wait_idle("R1", 400);
    chk("R1 word copied", mem[32'h200 >> 2], pat(32'h100));
  endtask

  // R10: mask, status, combined line and write-one-to-clear
  task automatic t_irq();
    chk("R10 raw after one-block chain", {27'd0, irq_raw}, 32'h0F);
    @(negedge clk); irq_mask = 5'b00010;
    @(negedge clk);
    chk("R10 masked status", {27'd0, irq_stat}, 32'h02);
    chk("R10 line with mask", {31'd0, irq}, 32'd1);
    irq_mask = 5'b10001; irq_clr = 5'b00001;
    @(negedge clk); irq_clr = 5'b0;
    chk("R10 clear tfr only", {27'd0, irq_raw}, 32'h0E);
    chk("R10 line after clear", {31'd0, irq}, 32'd0);
    irq_mask = 5'b0;
  endtask

  // R2, R3, R4, R6, R5: two-descriptor chain, destination continues
  task automatic t_chain();
    fresh();
    src_sw_sel = 1'b0; dst_sw_sel = 1'b0; src_auto = 1'b1; dst_auto = 1'b1;
    fill(32'h100, 3); fill(32'h140, 2);
    put_desc(32'h040, 32'h100, 32'h3F0, 32'h080, 32'd3);
    put_desc(32'h080, 32'h140, 32'h3E0, 32'h000, 32'd2);
    start_chan(32'h200, 32'h040);
    wait_idle("R5 chain", 1000);
    chk("R4 dst0", mem[32'h200 >> 2], pat(32'h100));
    chk("R4 dst1", mem[32'h204 >> 2], pat(32'h104));
    chk("R3 dst2 increment", mem[32'h208 >> 2], pat(32'h108));
    chk("R2 second block continues destination", mem[32'h20C >> 2], pat(32'h140));
    chk("R6 second block completes", mem[32'h210 >> 2], pat(32'h144));
    chk("R2 past end untouched", mem[32'h214 >> 2], 32'h5EB7_0000 | 32'h85);
    chk("R2 descriptor dst word ignored", mem[32'h3F0 >> 2], 32'h5EB7_0000 | 32'hFC);
    chk("R4 write count", n_wr, 5);
    chk("R7 src acks burst one", n_sack, 5);
    chk("R7 dst acks burst one", n_dack, 5);
    chk("R5 tfr and blk raised", {30'd0, irq_raw[1:0]}, 32'h3);
  endtask

  // R3, R4, R5: decrement source, fixed destination, burst 4, last bit ends chain
  task automatic t_modes();
    fresh();
    probe_addr = 32'h0C0;
    fill(32'h1E8, 6);
    put_desc(32'h040, 32'h1FC, 32'h3F0, 32'h0C0,
             32'd6 | (32'd1 << 12) | (32'd2 << 14) | (32'd1 << 16) | (32'd2 << 17));
    start_chan(32'h2F0, 32'h040);
    wait_idle("R5 modes", 1000);
    chk("R3 fixed dst holds last decremented word", mem[32'h2F0 >> 2], pat(32'h1E8));
    chk("R3 fixed dst neighbour untouched", mem[32'h2F4 >> 2], 32'h5EB7_0000 | 32'hBD);
    chk("R4 six writes", n_wr, 6);
    chk("R4 burst four then two", n_sack, 2);
    chk("R5 last bit stops before next pointer", n_probe, 0);
    probe_addr = 32'hFFFF_FFF0;
  endtask

  // R7: software source handshake, hardware request ignored
  task automatic t_swhs();
    fresh();
    src_sw_sel = 1'b1; src_auto = 1'b1; dst_auto = 1'b1;
    fill(32'h100, 2);
    put_desc(32'h040, 32'h100, 32'h3F0, 32'h000, 32'd2);
    start_chan(32'h260, 32'h040);
    repeat (40) @(negedge clk);
    chk("R7 hw request ignored in sw mode", n_wr, 0);
    src_sw_req = 1'b1; @(negedge clk); src_sw_req = 1'b0;
    repeat (40) @(negedge clk);
    chk("R7 one transaction per sw request", n_wr, 1);
    src_sw_req = 1'b1; @(negedge clk); src_sw_req = 1'b0;
    wait_idle("R7 sw", 400);
    chk("R7 second word", mem[32'h264 >> 2], pat(32'h104));
    chk("R7 no src ack in sw mode", n_sack, 0);
    chk("R7 dst acks in hw mode", n_dack, 2);
    src_sw_sel = 1'b0;
  endtask

  // R9: error response stops the chain
  task automatic t_err();
    fresh();
    err_addr = 32'h120;
    put_desc(32'h040, 32'h120, 32'h3F0, 32'h080, 32'd2);
    start_chan(32'h200, 32'h040);
    wait_idle("R9 error", 400);
    chk("R9 error flag", {31'd0, irq_raw[4]}, 32'd1);
    chk("R9 no transfer complete", {31'd0, irq_raw[0]}, 32'd0);
    chk("R9 nothing written", n_wr, 0);
    err_addr = 32'hFFFF_FFF0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_gate();
    t_irq();
    t_chain();
    t_modes();
    t_swhs();
    t_err();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule